// File: doc/BRIEF.md
# Atomic Memory Operation Sequencer

This block executes the 32-bit atomic instructions of a RISC-V core against a split-phase, single-port word memory. A caller pulses `start` with the operation code from instruction bits 31:27, the width code, the rs2 field, an address and a register operand. The sequencer then runs the memory accesses without interruption and raises `done` for one cycle. At that point the value for the destination register is on `result`, and the `illegal` and `fault` flags are valid.

Two kinds of operation are supported. The first is the read-modify-write group. It reads a word, combines it as the left operand with the register operand, writes the combined value back, and returns the word it read. The second is the load-reserved / store-conditional pair, which relies on one internal reservation made of an address and a valid bit. While a sequence is running, a new `start` is ignored.

The memory interface works in two phases. `mem_req` is high for exactly one cycle per access, and `mem_we` marks a write. The memory answers with a one-cycle `mem_ready` pulse no earlier than the next cycle. A read answer carries `mem_rdata`.

Top module: `amo_sequencer`

## Requirements
- R1: After reset, `done` and `mem_req` are low and no reservation is held, so a store-conditional issued first fails and returns 1.
- R2: A width code other than 3'b010, or an operation code outside {00000, 00001, 00010, 00011, 00100, 01000, 01100, 10000, 10100, 11000, 11100}, ends with `illegal`=1, `result`=0 and no memory request.
- R3: A load-reserved (code 00010) with a nonzero rs2 field is illegal. It behaves as in R2.
- R4: A legal operation whose address has low two bits other than 00 ends with `fault`=1, `illegal`=0, `result`=0 and no memory request. An illegal operation never reports `fault`.
- R5: The read-modify-write codes combine the memory word m with the operand r as follows: 00001 gives r, 00000 gives m+r, 00100 gives m^r, 01100 gives m&r, 01000 gives m|r, 10000 gives the signed minimum, 10100 the signed maximum, 11000 the unsigned minimum and 11100 the unsigned maximum. Each one does one read and then one write of the combined value, and returns m.
- R6: A load-reserved does one read and no write. It returns the word read and records that address as the reservation, replacing any earlier one.
- R7: A store-conditional (code 00011) whose address equals the held reservation does one write of the operand and returns 0.
- R8: A store-conditional with no matching reservation issues no memory request and returns 1.
- R9: Every legal, aligned store-conditional clears the reservation, whether it succeeds or fails.
- R10: `mem_req` never stays high for two cycles in a row. `done` is a one-cycle pulse. A `start` seen while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_code | input | 5 | Operation code, instruction bits 31:27 |
| width_code | input | 3 | Width field; only 3'b010 is legal |
| rs2_field | input | 5 | rs2 register index of the instruction |
| addr | input | AW | Byte address of the word |
| operand | input | DW | Register operand |
| result | output | DW | Value for the destination register |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Operation rejected as illegal (valid with done) |
| fault | output | 1 | Misaligned address (valid with done) |
| mem_req | output | 1 | One-cycle access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | One-cycle answer to a request |

## Verification
The assertions assume that the memory raises `mem_ready` only while the sequencer is waiting for an answer. That means never in the cycle of the request itself and never without an outstanding access. The memory model in the bench keeps to this rule. It starts a countdown of one to three cycles when it sees a request and pulses `mem_ready` once when the countdown ends. The random stimulus keeps addresses inside the modelled window. Half of the store-conditionals aim at the reserved address, so that both the success path and the failure path are reached.

// File: rtl/amo_sequencer.sv
module amo_sequencer #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [4:0]    op_code,
  input  logic [2:0]    width_code,
  input  logic [4:0]    rs2_field,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result,
  output logic          done,
  output logic          illegal,
  output logic          fault,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);

  localparam int OFS = $clog2(DW / 8);
  localparam logic [2:0] WORD_WIDTH = 3'b010;
  localparam logic [4:0] OP_ADD  = 5'b00000;
  localparam logic [4:0] OP_SWAP = 5'b00001;
  localparam logic [4:0] OP_LR   = 5'b00010;
  localparam logic [4:0] OP_SC   = 5'b00011;
  localparam logic [4:0] OP_XOR  = 5'b00100;
  localparam logic [4:0] OP_OR   = 5'b01000;
  localparam logic [4:0] OP_AND  = 5'b01100;
  localparam logic [4:0] OP_MIN  = 5'b10000;
  localparam logic [4:0] OP_MAX  = 5'b10100;
  localparam logic [4:0] OP_MINU = 5'b11000;
  localparam logic [4:0] OP_MAXU = 5'b11100;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_WAIT_READ, S_WRITE, S_WAIT_WRITE, S_DONE
  } state_t;

  state_t        state;
  logic [4:0]    op_r;
  logic [AW-1:0] addr_r;
  logic [DW-1:0] opnd_r;
  logic [DW-1:0] mval_r;
  logic [DW-1:0] result_r;
  logic          illegal_r, fault_r;
  logic          resv_valid;
  logic [AW-1:0] resv_addr;

  logic          is_rmw, is_lr, is_sc, bad_op, misaligned, resv_hit;
  logic [DW-1:0] combined;

  assign is_lr = op_code == OP_LR;
  assign is_sc = op_code == OP_SC;
  always_comb begin
    case (op_code)
      OP_ADD, OP_SWAP, OP_XOR, OP_OR, OP_AND,
      OP_MIN, OP_MAX, OP_MINU, OP_MAXU: is_rmw = 1'b1;
      default:                          is_rmw = 1'b0;
    endcase
  end
  assign bad_op     = (width_code != WORD_WIDTH) || !(is_rmw || is_lr || is_sc) ||
                      (is_lr && rs2_field != 5'd0);
  assign misaligned = addr[OFS-1:0] != '0;
  assign resv_hit   = resv_valid && (resv_addr == addr);

  always_comb begin
    case (op_r)
      OP_SWAP: combined = opnd_r;
      OP_ADD:  combined = mval_r + opnd_r;
      OP_XOR:  combined = mval_r ^ opnd_r;
      OP_AND:  combined = mval_r & opnd_r;
      OP_OR:   combined = mval_r | opnd_r;
      OP_MIN:  combined = ($signed(mval_r) < $signed(opnd_r)) ? mval_r : opnd_r;
      OP_MAX:  combined = ($signed(mval_r) > $signed(opnd_r)) ? mval_r : opnd_r;
      OP_MINU: combined = (mval_r < opnd_r) ? mval_r : opnd_r;
      OP_MAXU: combined = (mval_r > opnd_r) ? mval_r : opnd_r;
      default: combined = opnd_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_r       <= '0;
      addr_r     <= '0;
      opnd_r     <= '0;
      mval_r     <= '0;
      result_r   <= '0;
      illegal_r  <= 1'b0;
      fault_r    <= 1'b0;
      resv_valid <= 1'b0;
      resv_addr  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_r      <= op_code;
          addr_r    <= addr;
          opnd_r    <= operand;
          illegal_r <= bad_op;
          fault_r   <= !bad_op && misaligned;
          result_r  <= '0;
          if (bad_op || misaligned) begin
            state <= S_DONE;
          end else if (is_sc) begin
            resv_valid <= 1'b0;
            if (resv_hit) begin
              state <= S_WRITE;
            end else begin
              result_r <= DW'(1);
              state    <= S_DONE;
            end
          end else begin
            state <= S_READ;
          end
        end
        S_READ: state <= S_WAIT_READ;
        S_WAIT_READ: if (mem_ready) begin
          mval_r   <= mem_rdata;
          result_r <= mem_rdata;
          if (op_r == OP_LR) begin
            resv_valid <= 1'b1;
            resv_addr  <= addr_r;
            state      <= S_DONE;
          end else begin
            state <= S_WRITE;
          end
        end
        S_WRITE: state <= S_WAIT_WRITE;
        S_WAIT_WRITE: if (mem_ready) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == S_READ) || (state == S_WRITE);
  assign mem_we    = state == S_WRITE;
  assign mem_addr  = addr_r;
  assign mem_wdata = (state != S_WRITE) ? '0 : (op_r == OP_SC) ? opnd_r : combined;
  assign done      = state == S_DONE;
  assign result    = result_r;
  assign illegal   = illegal_r;
  assign fault     = fault_r;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R10
  AST_READY_WHEN_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |-> (state == S_WAIT_READ || state == S_WAIT_WRITE)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_NO_REQ_WHEN_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !illegal_r && !fault_r); // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(illegal && fault)); // R4
  AST_LR_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> op_r != OP_LR); // R6
  AST_SC_RESULT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_r == OP_SC) |-> result[DW-1:1] == '0); // R8
  AST_SC_CLEARS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_r == OP_SC && !illegal && !fault) |-> !resv_valid); // R9

endmodule

// File: tb/amo_sequencer_test.sv
`timescale 1ns/1ps
module amo_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  op_code = '0;
  logic [2:0]  width_code = 3'b010;
  logic [4:0]  rs2_field = '0;
  logic [31:0] addr = '0, operand = '0;
  logic [31:0] result, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        done, illegal, fault, mem_req, mem_we;
  logic        mem_ready = 1'b0;

  always #2 clk = ~clk;

  amo_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .width_code(width_code), .rs2_field(rs2_field), .addr(addr),
    .operand(operand), .result(result), .done(done), .illegal(illegal),
    .fault(fault), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  logic [31:0] mem [0:63];
  int cnt = 0, n_req = 0, n_wr = 0, cyc = 0;
  int n_chk = 0, n_bad = 0;

  always @(posedge clk) begin
    mem_ready <= 1'b0;
    if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) mem_ready <= 1'b1;
    end
    if (mem_req) begin
      n_req <= n_req + 1;
      mem_rdata <= mem[mem_addr[7:2]];
      cnt <= 1 + int'($urandom % 3);
      if (mem_we) begin
        n_wr <= n_wr + 1;
        mem[mem_addr[7:2]] <= mem_wdata;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit known_rmw(input logic [4:0] c);
    return c inside {5'b00000, 5'b00001, 5'b00100, 5'b01000, 5'b01100,
                     5'b10000, 5'b10100, 5'b11000, 5'b11100};
  endfunction

  function automatic logic [31:0] ref_combine(input logic [4:0] c, input logic [31:0] m, input logic [31:0] r);
    case (c)
      5'b00001: return r;
      5'b00000: return m + r;
      5'b00100: return m ^ r;
      5'b01100: return m & r;
      5'b01000: return m | r;
      5'b10000: return ($signed(m) <= $signed(r)) ? m : r;
      5'b10100: return ($signed(m) >= $signed(r)) ? m : r;
      5'b11000: return (m <= r) ? m : r;
      default:  return (m >= r) ? m : r;
    endcase
  endfunction

  bit          rv = 1'b0;
  logic [31:0] ra = '0;
  logic [31:0] r_res;
  bit          r_ill, r_flt;

  task automatic run_raw(input logic [4:0] c, input logic [2:0] w, input logic [4:0] s2,
                         input logic [31:0] a, input logic [31:0] o);
    @(negedge clk);
    op_code = c; width_code = w; rs2_field = s2; addr = a; operand = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60 && !done; i++) @(negedge clk);
    check(done === 1'b1, "R10 done seen", {31'd0, done}, 32'd1);
    r_res = result; r_ill = illegal; r_flt = fault;
    @(negedge clk);
    check(done === 1'b0, "R10 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic exec(input logic [4:0] c, input logic [2:0] w, input logic [4:0] s2,
                      input logic [31:0] a, input logic [31:0] o);
    bit ill, flt, hit;
    logic [31:0] old, exp_res, exp_mem;
    int exp_req, exp_wr, req0, wr0;
    string tag;
    old = mem[a[7:2]];
    exp_mem = old;
    ill = (w != 3'b010) || !(known_rmw(c) || c == 5'b00010 || c == 5'b00011) ||
          (c == 5'b00010 && s2 != 0);
    flt = !ill && a[1:0] != 2'b00;
    exp_res = 0; exp_req = 0; exp_wr = 0;
    if (ill) tag = (c == 5'b00010 && w == 3'b010) ? "R3" : "R2";
    else if (flt) tag = "R4";
    else if (c == 5'b00010) begin
      tag = "R6"; exp_res = old; exp_req = 1; rv = 1'b1; ra = a;
    end else if (c == 5'b00011) begin
      hit = rv && ra == a; rv = 1'b0;
      if (hit) begin tag = "R7"; exp_req = 1; exp_wr = 1; exp_mem = o; end
      else begin tag = "R8"; exp_res = 1; end
    end else begin
      tag = "R5"; exp_res = old; exp_req = 2; exp_wr = 1; exp_mem = ref_combine(c, old, o);
    end
    req0 = n_req; wr0 = n_wr;
    run_raw(c, w, s2, a, o);
    check(r_res === exp_res, {tag, " result"}, r_res, exp_res);
    check(r_ill === ill, {tag, " illegal"}, {31'd0, r_ill}, {31'd0, ill});
    check(r_flt === flt, {tag, " fault"}, {31'd0, r_flt}, {31'd0, flt});
    check(n_req - req0 == exp_req, {tag, " requests"}, n_req - req0, exp_req);
    check(n_wr - wr0 == exp_wr, {tag, " writes"}, n_wr - wr0, exp_wr);
    check(mem[a[7:2]] === exp_mem, {tag, " memory"}, mem[a[7:2]], exp_mem);
  endtask

  initial begin
    logic [4:0] codes [0:10];
    logic [31:0] keep;
    int r0;
    codes = '{5'b00000, 5'b00001, 5'b00100, 5'b01000, 5'b01100, 5'b10000,
              5'b10100, 5'b11000, 5'b11100, 5'b00010, 5'b00011};
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && mem_req === 1'b0, "R1 reset outputs", {30'd0, done, mem_req}, 32'd0);
    rst_n = 1'b1;
    exec(5'b00011, 3'b010, 5'd0, 32'h10, 32'h55);   // R1: SC right after reset fails

    mem[4] = 32'h8000_0000;
    for (int k = 0; k < 9; k++) begin               // R5: all nine combine codes
      mem[4] = (k % 2 == 0) ? 32'h8000_0000 : 32'h0000_0005;
      exec(codes[k], 3'b010, 5'd3, 32'h10, (k % 2 == 0) ? 32'h0000_0001 : 32'hFFFF_FFF0);
    end
    exec(5'b00010, 3'b010, 5'd1, 32'h20, 0);        // R3
    exec(5'b00000, 3'b011, 5'd0, 32'h20, 1);        // R2 width
    exec(5'b00101, 3'b010, 5'd0, 32'h20, 1);        // R2 code
    exec(5'b00000, 3'b010, 5'd0, 32'h22, 1);        // R4
    exec(5'b00010, 3'b010, 5'd0, 32'h30, 0);        // R6
    exec(5'b00011, 3'b010, 5'd0, 32'h30, 32'hCAFE); // R7
    exec(5'b00011, 3'b010, 5'd0, 32'h30, 32'hBEEF); // R9 cleared -> fails
    exec(5'b00010, 3'b010, 5'd0, 32'h34, 0);
    exec(5'b00011, 3'b010, 5'd0, 32'h38, 32'h1);    // R8 other address

    keep = mem[10]; r0 = n_req;                     // R10 start ignored while busy
    @(negedge clk);
    op_code = 5'b00001; width_code = 3'b010; rs2_field = 0; addr = 32'h24; operand = 32'h77; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    addr = 32'h28; operand = 32'h99; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 60 && !done; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(mem[10] === keep, "R10 busy start ignored", mem[10], keep);
    check(mem[9] === 32'h77 && n_req - r0 == 2, "R10 first op intact", mem[9], 32'h77);

    for (int n = 0; n < 400; n++) begin
      logic [4:0] c; logic [2:0] w; logic [4:0] s2; logic [31:0] a;
      int p = int'($urandom % 20);
      c = (p == 0) ? 5'($urandom) : codes[$urandom % 11];
      w = ($urandom % 16 == 0) ? 3'($urandom) : 3'b010;
      s2 = ($urandom % 8 == 0) ? 5'($urandom) : 5'd0;
      a = {24'd0, 6'($urandom), ($urandom % 10 == 0) ? 2'($urandom) : 2'b00};
      if (c == 5'b00011 && rv && $urandom % 2 == 0) a = ra;
      exec(c, w, s2, a, $urandom);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule